// File: doc/BRIEF.md
# Strobed Serial Receiver with Loopback

This block takes a serial bit stream on a serial clock and shifts it into a 39-stage register. When the strobe input is high at a rising edge, the word that sat in that register just before the edge is copied into a parallel holding register. The holding register drives the wide parallel output and keeps its value until the next strobe.

A second shift register returns the received data to the host so the host can confirm delivery. On a strobe it loads a copy of the receive register that is one clock older than the word placed in the holding register. On every other edge it shifts, and a divide-by-two of the serial clock fills it from the bottom. If strobes stop arriving, the loopback line therefore carries a toggling clock pattern rather than frozen data.

Both shift registers have two serial outputs. One is the last stage. The other is a tap seven stages earlier, which serves hosts that send 32-bit packets without the seven error-correction bits. A mode input chooses which feedback tap drives the loopback pin.

Top module: `srx_top`

## Requirements
- R1: While `rst_n` is low, `par_word`, `rx_sdo_full`, `rx_sdo_short` and `loop_out` are all 0.
- R2: At each rising edge of `clk`, `sdin` enters stage 0 of the receive register and every stage moves up by one. `rx_sdo_full` is stage 38, so it shows the bit received 39 edges earlier.
- R3: `rx_sdo_short` is stage 31 of the receive register, which is 7 stages before the end. It shows the bit received 32 edges earlier.
- R4: A high `sstr` at a rising edge copies the receive register as it stood before that edge into `par_word`. When `sstr` is low, `par_word` does not change.
- R5: In `par_word`, bit 0 is the most recently received bit and bit 38 is the oldest of the 39 bits captured.
- R6: A high `sstr` at edge k loads the feedback register with the receive register contents as they stood before edge k-1, which is one clock older than the word captured in `par_word`.
- R7: When `sstr` is low, the feedback register shifts up by one at every edge. Its stage 0 takes a divider bit that is 0 after reset and inverts at every edge. With no strobe after reset and `ecc_mode`=1, `loop_out` after edge k (k≥39) equals (k+1) mod 2.
- R8: With `ecc_mode`=1, `loop_out` shows feedback stage 38. With `ecc_mode`=0, it shows feedback stage 31. The choice is combinational.
- R9: A strobe overrides the shift. With `sstr` high on consecutive edges, the feedback register reloads at each edge and never shifts.
- R10: Reset is asynchronous. Pulling `rst_n` low between clock edges clears all outputs at once, without waiting for an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdin | input | 1 | Serial data input |
| sstr | input | 1 | Strobe: captures the word and reloads the feedback register |
| ecc_mode | input | 1 | 1 selects the full-length loopback tap, 0 selects the short tap |
| par_word | output | 39 | Captured parallel word |
| rx_sdo_full | output | 1 | Last stage of the receive register |
| rx_sdo_short | output | 1 | Receive register stage 7 before the end |
| loop_out | output | 1 | Loopback line from the feedback register |

## Verification
The assertions check the following on every cycle:
- one-edge entry of `sdin` into the receive register and the movement to its last stage;
- the divider inverting at every edge;
- `par_word` loading on a strobe and holding without one;
- the two-clock-old word reaching the feedback register on a strobe;
- the divider bit entering the feedback register when no strobe is present.

Only the bench scenarios can show the following:
- the absolute bit order and tap positions seen at the pins;
- the toggling loopback pattern that appears only after the feedback register fills;
- the combinational switching of the `ecc_mode` tap;
- strobe priority across back-to-back strobes;
- the clearing by a reset that arrives between edges.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int SRX_LEN       = 39;
    localparam int SRX_SHORT_GAP = 7;

    typedef enum logic {
        LOOP_SHORT = 1'b0,
        LOOP_FULL  = 1'b1
    } loop_sel_e;
endpackage

// File: rtl/srx_tap_pair.sv
module srx_tap_pair #(
    parameter int LEN = 39,
    parameter int GAP = 7
) (
    input  logic [LEN-1:0] word,
    output logic           tap_full,
    output logic           tap_short
);
    assign tap_full = word[LEN-1];

    generate
        if (GAP > 0 && GAP < LEN) begin : g_short
            localparam int SHORT_IDX = LEN - 1 - GAP;
            assign tap_short = word[SHORT_IDX];
        end else begin : g_same
            assign tap_short = word[LEN-1];
        end
    endgenerate
endmodule

// File: rtl/srx_capture.sv
module srx_capture #(
    parameter int LEN = 39,
    parameter int GAP = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sdin,
    input  logic           sstr,
    output logic [LEN-1:0] rx_word,
    output logic [LEN-1:0] dly_word,
    output logic [LEN-1:0] hold_word,
    output logic           tap_full,
    output logic           tap_short
);
    typedef struct packed {
        logic [LEN-1:0] shift;
        logic [LEN-1:0] dly;
        logic [LEN-1:0] hold;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.shift = {st_q.shift[LEN-2:0], sdin};
        st_d.dly   = st_q.shift;
        if (sstr) begin
            st_d.hold = st_q.shift;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_word   = st_q.shift;
    assign dly_word  = st_q.dly;
    assign hold_word = st_q.hold;

    srx_tap_pair #(.LEN(LEN), .GAP(GAP)) u_taps (
        .word      (st_q.shift),
        .tap_full  (tap_full),
        .tap_short (tap_short)
    );
endmodule

// File: rtl/srx_loopback.sv
module srx_loopback
    import srx_pkg::*;
#(
    parameter int LEN = 39,
    parameter int GAP = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sstr,
    input  logic [LEN-1:0] load_word,
    input  logic           sel,
    output logic [LEN-1:0] fb_word,
    output logic           div_bit,
    output logic           loop_out
);
    typedef struct packed {
        logic [LEN-1:0] fb;
        logic           div;
    } fb_t;

    fb_t  st_d, st_q;
    logic fb_full, fb_short;

    always_comb begin
        st_d     = st_q;
        st_d.div = ~st_q.div;
        if (sstr) begin
            st_d.fb = load_word;
        end else begin
            st_d.fb = {st_q.fb[LEN-2:0], st_q.div};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    srx_tap_pair #(.LEN(LEN), .GAP(GAP)) u_taps (
        .word      (st_q.fb),
        .tap_full  (fb_full),
        .tap_short (fb_short)
    );

    assign fb_word  = st_q.fb;
    assign div_bit  = st_q.div;
    assign loop_out = (loop_sel_e'(sel) == LOOP_FULL) ? fb_full : fb_short;
endmodule

// File: rtl/srx_top.sv
module srx_top
    import srx_pkg::*;
#(
    parameter int LEN = SRX_LEN,
    parameter int GAP = SRX_SHORT_GAP
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sdin,
    input  logic           sstr,
    input  logic           ecc_mode,
    output logic [LEN-1:0] par_word,
    output logic           rx_sdo_full,
    output logic           rx_sdo_short,
    output logic           loop_out
);
    logic [LEN-1:0] rx_word;
    logic [LEN-1:0] dly_word;
    logic [LEN-1:0] fb_word;
    logic           div_bit;

    srx_capture #(.LEN(LEN), .GAP(GAP)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .sdin      (sdin),
        .sstr      (sstr),
        .rx_word   (rx_word),
        .dly_word  (dly_word),
        .hold_word (par_word),
        .tap_full  (rx_sdo_full),
        .tap_short (rx_sdo_short)
    );

    srx_loopback #(.LEN(LEN), .GAP(GAP)) u_loop (
        .clk       (clk),
        .rst_n     (rst_n),
        .sstr      (sstr),
        .load_word (dly_word),
        .sel       (ecc_mode),
        .fb_word   (fb_word),
        .div_bit   (div_bit),
        .loop_out  (loop_out)
    );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int LEN = 39
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sdin,
    input logic           sstr,
    input logic [LEN-1:0] par_word,
    input logic           rx_sdo_full,
    input logic [LEN-1:0] rx_word,
    input logic [LEN-1:0] fb_word,
    input logic           div_bit
);
    // R2: new bit lands in stage 0
    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rx_word[0] == $past(sdin));

    // R2: last stage follows the stage beneath it
    p_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rx_sdo_full == $past(rx_word[LEN-2]));

    // R4: capture on strobe
    p_hold_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(sstr) |-> par_word == $past(rx_word));

    // R4: hold without strobe
    p_hold_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(sstr) |-> par_word == $past(par_word));

    // R6: feedback gets the word from one clock before the capture
    p_fb_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) && $past(rst_n) && $past(sstr) |-> fb_word == $past(rx_word, 2));

    // R7: divider inverts at every edge
    p_div_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> div_bit != $past(div_bit));

    // R7: divider feeds stage 0 when no strobe
    p_fb_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(sstr) |-> fb_word[0] == $past(div_bit));
endmodule

bind srx_top srx_checker #(.LEN(LEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sdin        (sdin),
    .sstr        (sstr),
    .par_word    (par_word),
    .rx_sdo_full (rx_sdo_full),
    .rx_word     (rx_word),
    .fb_word     (fb_word),
    .div_bit     (div_bit)
);

// File: tb/srx_top_test.sv
module srx_top_test;
    localparam int LEN = 39;
    localparam logic [LEN-1:0] W1 = 39'h5A_C3F0_9E71;
    localparam logic [LEN-1:0] W2 = 39'h2F_0F0F_A5A5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sdin = 1'b0;
    logic           sstr = 1'b0;
    logic           ecc_mode = 1'b1;
    logic [LEN-1:0] par_word;
    logic           rx_sdo_full, rx_sdo_short, loop_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    srx_top uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sdin         (sdin),
        .sstr         (sstr),
        .ecc_mode     (ecc_mode),
        .par_word     (par_word),
        .rx_sdo_full  (rx_sdo_full),
        .rx_sdo_short (rx_sdo_short),
        .loop_out     (loop_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sdin = 1'b0; sstr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic tick(input logic sd, input logic st);
        sdin = sd; sstr = st;
        @(posedge clk);
        @(negedge clk);
        sstr = 1'b0;
    endtask

    task automatic push_word(input logic [LEN-1:0] w);
        for (int i = LEN - 1; i >= 0; i--) tick(w[i], 1'b0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 par_word", 64'(par_word), 64'd0);
        chk("R1 rx_sdo_full", 64'(rx_sdo_full), 64'd0);
        chk("R1 rx_sdo_short", 64'(rx_sdo_short), 64'd0);
        chk("R1 loop_out", 64'(loop_out), 64'd0);
    endtask

    task automatic test_shift_taps();
        do_reset();
        push_word(W1);
        chk("R2 full tap", 64'(rx_sdo_full), 64'(W1[38]));
        chk("R3 short tap", 64'(rx_sdo_short), 64'(W1[31]));
        chk("R4 no strobe keeps par_word", 64'(par_word), 64'd0);
        tick(1'b0, 1'b0);
        chk("R2 full tap next", 64'(rx_sdo_full), 64'(W1[37]));
        chk("R3 short tap next", 64'(rx_sdo_short), 64'(W1[30]));
    endtask

    task automatic test_capture();
        do_reset();
        push_word(W2);
        tick(1'b1, 1'b1);
        chk("R5 captured word order", 64'(par_word), 64'(W2));
        repeat (3) tick(1'b1, 1'b0);
        chk("R4 hold after strobe", 64'(par_word), 64'(W2));
    endtask

    task automatic test_feedback_load();
        do_reset();
        push_word(W2);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b1);
        chk("R4 captured word", 64'(par_word), 64'({W2[37:0], 1'b1}));
        ecc_mode = 1'b1; #1;
        chk("R6 R8 full loop tap", 64'(loop_out), 64'(W2[38]));
        ecc_mode = 1'b0; #1;
        chk("R6 R8 short loop tap", 64'(loop_out), 64'(W2[31]));
        for (int t = 1; t <= 4; t++) begin
            tick(1'b0, 1'b0);
            ecc_mode = 1'b1; #1;
            chk("R6 R8 full shifted", 64'(loop_out), 64'(W2[38-t]));
            ecc_mode = 1'b0; #1;
            chk("R6 R8 short shifted", 64'(loop_out), 64'(W2[31-t]));
        end
        ecc_mode = 1'b1;
    endtask

    task automatic test_divider_fill();
        do_reset();
        ecc_mode = 1'b1;
        for (int k = 1; k <= 44; k++) begin
            tick(k[0], 1'b0);
            if (k >= 39) begin
                ecc_mode = 1'b1; #1;
                chk("R7 toggle pattern full", 64'(loop_out), 64'((k + 1) & 1));
            end
            if (k >= 32) begin
                ecc_mode = 1'b0; #1;
                chk("R7 R8 toggle pattern short", 64'(loop_out), 64'((k - 32) & 1));
            end
        end
        ecc_mode = 1'b1;
    endtask

    task automatic test_priority();
        do_reset();
        push_word(W1);
        tick(1'b0, 1'b1);
        tick(1'b1, 1'b1);
        chk("R9 par_word on second strobe", 64'(par_word), 64'({W1[37:0], 1'b0}));
        ecc_mode = 1'b1; #1;
        chk("R9 reload wins full", 64'(loop_out), 64'(W1[38]));
        ecc_mode = 1'b0; #1;
        chk("R9 reload wins short", 64'(loop_out), 64'(W1[31]));
        ecc_mode = 1'b1;
    endtask

    task automatic test_async_reset();
        do_reset();
        push_word(W1);
        tick(1'b1, 1'b1);
        #2;
        rst_n = 1'b0;
        #1;
        chk("R10 par_word cleared", 64'(par_word), 64'd0);
        chk("R10 rx_sdo_full cleared", 64'(rx_sdo_full), 64'd0);
        chk("R10 loop_out cleared", 64'(loop_out), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        test_reset();
        test_shift_taps();
        test_capture();
        test_feedback_load();
        test_divider_fill();
        test_priority();
        test_async_reset();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule